// File: doc/BRIEF.md
# Frame-Locked Calibration Timebase Sequencer

This block produces the sampling strobe for an optical power calibration path and keeps its phase tied to a frame sync. Each converter sample arrives as a one-cycle `smp_en` pulse. A fixed divide-by-8 stage turns the interleaved converter rate into the per-channel rate. A programmable divide-by-N stage, with N from 1 to 16, then sets the strobe rate. The frame sync is either the rising edge of an external input or a pulse from an internal generator. The internal generator fires after a programmable number of strobes. Each selected sync event clears both divider stages, so the first strobe of every frame has the same phase relative to the sync.

A processor may write the control values in any cycle. The divide factor, frame length and operating mode are held in a shadow copy. They move into the active copy only at the next sync event, so acquisition never sees a half-applied setting. The sync-source select is the exception: it takes effect on the clock after the write. This lets the block fall back to the internal generator when no external sync is present.

The block also provides:
- a sample index that counts strobes within the frame;
- a registered copy of the selected sync event;
- a sample-memory write enable. It follows the strobe only in the modes that store samples: power-stepped recording, fixed-power recording and calibration read-back. Normal read, alternate read and detector-only mode never write.

Top module: `cal_timebase_seq`

## Requirements
- R1: After reset, all of these are 0: `tb_stb`, `sync_pulse`, `mem_we`, `smp_idx`, `act_div`, `act_mode` and `act_src`. `act_period` holds the default frame length of 588.
- R2: `tb_stb` is a one-cycle pulse. With active divide field D, it rises on the clock after every 8·(D+1)-th `smp_en` pulse.
- R3: A sync event clears both divider stages. With `smp_en` held high, the first `tb_stb` after a sync comes exactly 8·(D+1) cycles after the `sync_pulse` cycle.
- R4: When `act_src` is 0, a sync event occurs on each clock where `ext_sync` is high after having been low on the previous clock. A level that stays high gives a single event.
- R5: When `act_src` is 1 and the active frame length is P (0 treated as 1), a sync event occurs on the clock after the strobe with index P-1. Consecutive `sync_pulse` outputs are therefore P strobes apart. External edges are ignored.
- R6: `sync_pulse` is high for one cycle, on the clock after each sync event. In that cycle `smp_idx` is 0 and `tb_stb` is low.
- R7: While a strobe is high, `smp_idx` equals the number of strobes since the last sync event, counting modulo 2^IDX_W.
- R8: A `cfg_wr` pulse loads `cfg_div`, `cfg_period` and `cfg_mode` into a shadow copy. The active outputs take the shadow at the next sync event and stay unchanged otherwise. A write in the same cycle as a sync event waits for the following event.
- R9: `act_src` takes `cfg_src` on the clock after `cfg_wr`, with no sync event needed. This lets the internal generator take over when the external sync is absent.
- R10: `mem_we` is high exactly when `tb_stb` is high and `act_mode` is 0 (power-stepped record), 1 (fixed-power record) or 2 (calibration read). It is never high for mode 3 (normal read), 4 (alternate read), 5 (detector only), 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| smp_en | input | 1 | One-cycle pulse per converter sample |
| ext_sync | input | 1 | External frame sync level |
| cfg_wr | input | 1 | Processor write strobe for the control values |
| cfg_div | input | DIV_W | Divide field; value N-1 selects divide-by-N |
| cfg_period | input | PER_W | Internal frame length in strobes |
| cfg_mode | input | 3 | Operating mode code |
| cfg_src | input | 1 | Sync source: 0 external, 1 internal |
| tb_stb | output | 1 | Timebase strobe |
| sync_pulse | output | 1 | Registered selected sync event |
| smp_idx | output | IDX_W | Strobe index within the frame |
| mem_we | output | 1 | Sample-memory write enable |
| act_div | output | DIV_W | Active divide field |
| act_period | output | PER_W | Active internal frame length |
| act_mode | output | 3 | Active mode |
| act_src | output | 1 | Active sync source |

## Verification
The assertions assume that `smp_en` and the configuration inputs are synchronous single-clock signals. They also assume that a divide change reaches the prescaler only together with the counter clear that a sync event causes. The stimulus respects both assumptions: every input changes on the falling edge, and control values reach the design only through `cfg_wr`. The random mix keeps frame lengths and divide factors small, so that many frames, source switches and writes that land on sync events happen within the run. Directed cases cover the strobe distance after a sync, the switch to the internal source with no external sync present, and the non-storing modes.

// File: rtl/cts_pkg.sv
package cts_pkg;

   typedef enum logic [2:0] {
      MODE_REC_STEP  = 3'd0,
      MODE_REC_FIXED = 3'd1,
      MODE_CAL_READ  = 3'd2,
      MODE_MON_READ  = 3'd3,
      MODE_ALT_READ  = 3'd4,
      MODE_DET_ONLY  = 3'd5
   } mode_t;

   // modes that write acquired samples to memory
   function automatic logic mode_stores(input logic [2:0] m);
      return (m <= 3'(MODE_CAL_READ));
   endfunction

endpackage

// File: rtl/cts_sync_src.sv
module cts_sync_src #(
   parameter int PER_W       = 10,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_sync,
   input  logic             src_int,
   input  logic             tb_stb,
   input  logic [PER_W-1:0] period,
   output logic             sel_rise
);

   localparam int CW = PER_W + 1;

   logic             ext_s;
   logic             ext_q;
   logic [PER_W-1:0] str_cnt;
   logic             int_pulse;
   logic [CW-1:0]    cnt_next;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign ext_s = ext_sync;
      end else begin : g_retime
         logic [SYNC_STAGES-1:0] ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ff <= '0;
            end else begin
               ff[0] <= ext_sync;
               for (int i = 1; i < SYNC_STAGES; i++) ff[i] <= ff[i-1];
            end
         end
         assign ext_s = ff[SYNC_STAGES-1];
      end
   endgenerate

   assign cnt_next = {1'b0, str_cnt} + CW'(1);
   assign sel_rise = src_int ? int_pulse : (ext_s & ~ext_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_q     <= 1'b0;
         str_cnt   <= '0;
         int_pulse <= 1'b0;
      end else begin
         ext_q     <= ext_s;
         int_pulse <= 1'b0;
         if (sel_rise) begin
            str_cnt <= '0;
         end else if (tb_stb) begin
            if (cnt_next >= {1'b0, period}) begin
               str_cnt   <= '0;
               int_pulse <= 1'b1;
            end else begin
               str_cnt <= str_cnt + PER_W'(1);
            end
         end
      end
   end

   // R5: an internal sync only follows a strobe
   assert_int_after_stb_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      int_pulse |-> $past(tb_stb));

endmodule

// File: rtl/cts_prescale.sv
module cts_prescale #(
   parameter int DIV_W    = 4,
   parameter int PRE_LOG2 = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_en,
   input  logic             clr,
   input  logic [DIV_W-1:0] div,
   output logic             stb
);

   logic             tick;
   logic [DIV_W-1:0] pc;

   generate
      if (PRE_LOG2 == 0) begin : g_nopre
         assign tick = smp_en;
      end else begin : g_pre
         logic [PRE_LOG2-1:0] c;
         assign tick = smp_en && (c == {PRE_LOG2{1'b1}});
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      c <= '0;
            else if (clr)    c <= '0;
            else if (smp_en) c <= c + PRE_LOG2'(1);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc  <= '0;
         stb <= 1'b0;
      end else if (clr) begin
         pc  <= '0;
         stb <= 1'b0;
      end else begin
         stb <= 1'b0;
         if (tick) begin
            if (pc >= div) begin
               pc  <= '0;
               stb <= 1'b1;
            end else begin
               pc <= pc + DIV_W'(1);
            end
         end
      end
   end

   assert_stb_needs_sample_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      stb |-> $past(smp_en));

   assert_pc_in_range_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      pc <= div);

endmodule

// File: rtl/cts_cfg_hold.sv
module cts_cfg_hold #(
   parameter int DIV_W   = 4,
   parameter int PER_W   = 10,
   parameter int PER_RST = 588
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [DIV_W-1:0] wr_div,
   input  logic [PER_W-1:0] wr_period,
   input  logic [2:0]       wr_mode,
   input  logic             wr_src,
   input  logic             apply,
   output logic [DIV_W-1:0] act_div,
   output logic [PER_W-1:0] act_period,
   output logic [2:0]       act_mode,
   output logic             act_src
);

   logic [DIV_W-1:0] sh_div;
   logic [PER_W-1:0] sh_period;
   logic [2:0]       sh_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_div     <= '0;
         sh_period  <= PER_W'(PER_RST);
         sh_mode    <= '0;
         act_div    <= '0;
         act_period <= PER_W'(PER_RST);
         act_mode   <= '0;
         act_src    <= 1'b0;
      end else begin
         if (wr) begin
            sh_div    <= wr_div;
            sh_period <= wr_period;
            sh_mode   <= wr_mode;
            act_src   <= wr_src;
         end
         if (apply) begin
            act_div    <= sh_div;
            act_period <= sh_period;
            act_mode   <= sh_mode;
         end
      end
   end

   assert_hold_between_syncs_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !apply |=> $stable({act_div, act_period, act_mode}));

   assert_src_immediate_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (act_src == $past(wr_src)));

endmodule

// File: rtl/cal_timebase_seq.sv
module cal_timebase_seq
   import cts_pkg::*;
#(
   parameter int DIV_W       = 4,
   parameter int PER_W       = 10,
   parameter int IDX_W       = 10,
   parameter int PRE_LOG2    = 3,
   parameter int SYNC_STAGES = 0,
   parameter int PER_RST     = 588
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_en,
   input  logic             ext_sync,
   input  logic             cfg_wr,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic [PER_W-1:0] cfg_period,
   input  logic [2:0]       cfg_mode,
   input  logic             cfg_src,
   output logic             tb_stb,
   output logic             sync_pulse,
   output logic [IDX_W-1:0] smp_idx,
   output logic             mem_we,
   output logic [DIV_W-1:0] act_div,
   output logic [PER_W-1:0] act_period,
   output logic [2:0]       act_mode,
   output logic             act_src
);

   generate
      if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
         $error("DIV_W out of range");
      end
      if (PRE_LOG2 < 0 || PRE_LOG2 > 6) begin : g_bad_pre
         $error("PRE_LOG2 out of range");
      end
      if (PER_W < 1 || PER_RST >= (1 << PER_W)) begin : g_bad_per
         $error("PER_RST does not fit PER_W");
      end
      if (IDX_W < 1 || SYNC_STAGES < 0) begin : g_bad_misc
         $error("IDX_W or SYNC_STAGES invalid");
      end
   endgenerate

   logic sel_rise;

   cts_sync_src #(.PER_W(PER_W), .SYNC_STAGES(SYNC_STAGES)) u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .ext_sync (ext_sync),
      .src_int  (act_src),
      .tb_stb   (tb_stb),
      .period   (act_period),
      .sel_rise (sel_rise)
   );

   cts_prescale #(.DIV_W(DIV_W), .PRE_LOG2(PRE_LOG2)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .smp_en (smp_en),
      .clr    (sel_rise),
      .div    (act_div),
      .stb    (tb_stb)
   );

   cts_cfg_hold #(.DIV_W(DIV_W), .PER_W(PER_W), .PER_RST(PER_RST)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (cfg_wr),
      .wr_div     (cfg_div),
      .wr_period  (cfg_period),
      .wr_mode    (cfg_mode),
      .wr_src     (cfg_src),
      .apply      (sel_rise),
      .act_div    (act_div),
      .act_period (act_period),
      .act_mode   (act_mode),
      .act_src    (act_src)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_idx    <= '0;
         sync_pulse <= 1'b0;
      end else begin
         sync_pulse <= sel_rise;
         if (sel_rise)    smp_idx <= '0;
         else if (tb_stb) smp_idx <= smp_idx + IDX_W'(1);
      end
   end

   assign mem_we = tb_stb & mode_stores(act_mode);

   assert_frame_start_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      sync_pulse |-> (smp_idx == '0 && !tb_stb));

endmodule

// File: tb/cal_timebase_seq_test.sv
module cal_timebase_seq_test;

   localparam int CLK_PERIOD = 10;
   localparam int DIV_W = 4;
   localparam int PER_W = 10;
   localparam int IDX_W = 10;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             smp_en = 1'b0;
   logic             ext_sync = 1'b0;
   logic             cfg_wr = 1'b0;
   logic [DIV_W-1:0] cfg_div = '0;
   logic [PER_W-1:0] cfg_period = '0;
   logic [2:0]       cfg_mode = '0;
   logic             cfg_src = 1'b0;
   logic             tb_stb, sync_pulse, mem_we, act_src;
   logic [IDX_W-1:0] smp_idx;
   logic [DIV_W-1:0] act_div;
   logic [PER_W-1:0] act_period;
   logic [2:0]       act_mode;

   int checks = 0;
   int errors = 0;
   bit model_on = 1'b0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cal_timebase_seq uut (
      .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .ext_sync(ext_sync),
      .cfg_wr(cfg_wr), .cfg_div(cfg_div), .cfg_period(cfg_period),
      .cfg_mode(cfg_mode), .cfg_src(cfg_src), .tb_stb(tb_stb),
      .sync_pulse(sync_pulse), .smp_idx(smp_idx), .mem_we(mem_we),
      .act_div(act_div), .act_period(act_period), .act_mode(act_mode),
      .act_src(act_src)
   );

   // expected-value model built from the requirements
   logic             m_extq, m_ip, m_stb, m_sync, a_src;
   int               m_ic, m_c8, m_pc, m_idx;
   int               s_div, s_per, s_mode, a_div, a_per, a_mode;

   function automatic bit exp_we(input bit stb, input int mode);
      return stb && (mode <= 2);   // R10
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_extq = 0; m_ip = 0; m_stb = 0; m_sync = 0; a_src = 0;
         m_ic = 0; m_c8 = 0; m_pc = 0; m_idx = 0;
         s_div = 0; s_per = 588; s_mode = 0;
         a_div = 0; a_per = 588; a_mode = 0;
      end else begin
         bit ev;
         ev = a_src ? m_ip : (ext_sync && !m_extq);
         m_extq = ext_sync;
         if (ev) begin
            m_ic = 0; m_ip = 0;
         end else if (m_stb && (m_ic + 1 >= a_per)) begin
            m_ic = 0; m_ip = 1;
         end else begin
            m_ip = 0;
            if (m_stb) m_ic++;
         end
         if (ev) m_idx = 0;
         else if (m_stb) m_idx = (m_idx + 1) % (1 << IDX_W);
         if (ev) begin
            m_c8 = 0; m_pc = 0; m_stb = 0;
         end else begin
            m_stb = 0;
            if (smp_en) begin
               if (m_c8 == 7) begin
                  m_c8 = 0;
                  if (m_pc >= a_div) begin m_pc = 0; m_stb = 1; end
                  else m_pc++;
               end else m_c8++;
            end
         end
         m_sync = ev;
         if (ev) begin a_div = s_div; a_per = s_per; a_mode = s_mode; end
         if (cfg_wr) begin
            s_div = int'(cfg_div); s_per = int'(cfg_period);
            s_mode = int'(cfg_mode); a_src = cfg_src;
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (model_on && rst_n) begin
         check("R2 R3 tb_stb", int'(tb_stb), int'(m_stb));
         check("R4 R5 R6 sync_pulse", int'(sync_pulse), int'(m_sync));
         check("R7 smp_idx", int'(smp_idx), m_idx);
         check("R10 mem_we", int'(mem_we), int'(exp_we(m_stb, a_mode)));
         check("R8 act_div", int'(act_div), a_div);
         check("R8 act_period", int'(act_period), a_per);
         check("R8 act_mode", int'(act_mode), a_mode);
         check("R9 act_src", int'(act_src), int'(a_src));
      end
   end

   task automatic write_cfg(input int d, input int p, input int m, input bit s);
      cfg_div = DIV_W'(d); cfg_period = PER_W'(p); cfg_mode = 3'(m);
      cfg_src = s; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic ext_pulse();
      ext_sync = 1'b1;
      repeat (3) @(negedge clk);
      ext_sync = 1'b0;
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      int t, n, w;
      void'($urandom(32'd5150));
      repeat (4) @(negedge clk);
      // R1 reset state
      check("R1 tb_stb", int'(tb_stb), 0);
      check("R1 sync_pulse", int'(sync_pulse), 0);
      check("R1 mem_we", int'(mem_we), 0);
      check("R1 smp_idx", int'(smp_idx), 0);
      check("R1 act_div", int'(act_div), 0);
      check("R1 act_period", int'(act_period), 588);
      check("R1 act_mode", int'(act_mode), 0);
      check("R1 act_src", int'(act_src), 0);
      rst_n = 1'b1;
      @(negedge clk);
      model_on = 1'b1;

      // R8: write is held until a sync
      write_cfg(2, 4, 0, 1'b0);
      repeat (5) @(negedge clk);
      check("R8 held before sync", int'(act_div), 0);
      smp_en = 1'b1;
      // R3: distance from sync to first strobe
      ext_sync = 1'b1;
      t = 0;
      while (!sync_pulse && t < 100) begin @(negedge clk); t++; end
      check("R8 applied at sync", int'(act_div), 2);
      t = 0;
      while (!tb_stb && t < 200) begin @(negedge clk); t++; end
      check("R3 first strobe distance", t, 24);
      ext_sync = 1'b0;   // R4: level stayed high, one event only

      // R9 and R5: switch to internal source, no external sync present
      write_cfg(2, 4, 0, 1'b1);
      check("R9 src immediate", int'(act_src), 1);
      t = 0;
      while (!sync_pulse && t < 500) begin @(negedge clk); t++; end
      check("R5 internal sync appears", int'(sync_pulse), 1);
      @(negedge clk);
      n = 0; t = 0;
      while (!sync_pulse && t < 500) begin
         if (tb_stb) n++;
         @(negedge clk); t++;
      end
      check("R5 strobes per internal frame", n, 4);

      // R10: detector-only mode never writes memory
      write_cfg(0, 3, 5, 1'b1);
      t = 0;
      @(negedge clk);
      while (!sync_pulse && t < 500) begin @(negedge clk); t++; end
      n = 0; w = 0;
      repeat (120) begin
         if (tb_stb) n++;
         if (mem_we) w++;
         @(negedge clk);
      end
      check("R10 strobes present mode 5", int'(n > 0), 1);
      check("R10 no write mode 5", w, 0);
      write_cfg(0, 3, 2, 1'b1);
      t = 0;
      @(negedge clk);
      while (!sync_pulse && t < 500) begin @(negedge clk); t++; end
      n = 0; w = 0;
      repeat (120) begin
         if (tb_stb) n++;
         if (mem_we) w++;
         @(negedge clk);
      end
      check("R10 write per strobe mode 2", w, n);

      // random mix against the model
      for (int i = 0; i < 30000; i++) begin
         smp_en = ($urandom % 4) != 0;
         if (!ext_sync && ($urandom % 150) == 0) ext_sync = 1'b1;
         else if (ext_sync && ($urandom % 3) == 0) ext_sync = 1'b0;
         if (($urandom % 120) == 0) begin
            cfg_div = DIV_W'($urandom % 4);
            cfg_period = PER_W'($urandom % 7);
            cfg_mode = 3'($urandom % 8);
            cfg_src = ($urandom % 2) == 1;
            cfg_wr = 1'b1;
         end else begin
            cfg_wr = 1'b0;
         end
         @(negedge clk);
      end
      cfg_wr = 1'b0;
      repeat (4) @(negedge clk);
      done = 1'b1;
      finish_run();
   end

endmodule